// File: doc/BRIEF.md
# Illegal Condition Reset Detector

This block sits beside a processor pipeline and turns three kinds of illegal behaviour into one device-reset request. It flags an executed instruction word whose top byte carries the reserved illegal opcode value. It flags an attempt to dereference a working register that nothing has written since the last reset. It also flags a program-counter reload, whether from a branch-type instruction or from an interrupt or trap vector, whose target falls inside a restricted window of a protected memory segment.

The request is registered and lasts exactly one clock. A two-bit cause code comes with it so that the reset controller can record why the reset happened. When more than one condition occurs in the same cycle, a fixed priority picks the reported cause. Each of the two protected segments, boot and secure, is set up with an enable bit and an inclusive address window.

Top module: `illegal_reset_det`

## Requirements
- R1: After reset, `rst_req` is 0, `rst_cause` is 00, and registers 0 to 14 are treated as uninitialized.
- R2: When `fetch_vld` is high and `fetch_word[23:16]` equals 8'h3F, `rst_req` goes high on the next clock with cause 01.
- R3: When `ptr_use` is high and register `ptr_idx` is uninitialized, `rst_req` goes high on the next clock with cause 10.
- R4: A write (`wr_en`, `wr_idx`) marks its register initialized from the following cycle until reset. A use in the same cycle as the write still sees the register as uninitialized.
- R5: Register 15 always counts as initialized, so its use never raises a request.
- R6: When `pc_branch` or `pc_vector` is high and `pc_target` lies inside an enabled segment window, `rst_req` goes high on the next clock with cause 11. Both kinds of reload are checked the same way.
- R7: Window bounds are inclusive: the addresses lo and hi hit, while lo-1 and hi+1 do not. A segment whose enable bit is low never hits.
- R8: When several conditions occur in one cycle, the reported cause follows the order illegal opcode (01), then security (11), then uninitialized register (10).
- R9: `rst_req` is never high for two cycles in a row. A condition seen in the cycle right after a request is dropped, and `rst_cause` is 00 whenever `rst_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_vld | input | 1 | Instruction word reaches execution |
| fetch_word | input | 24 | Executed instruction word |
| wr_en | input | 1 | Working-register write strobe |
| wr_idx | input | 4 | Written register index |
| ptr_use | input | 1 | Register used as address pointer |
| ptr_idx | input | 4 | Pointer register index |
| pc_branch | input | 1 | Program-flow reload (call, jump, return, branch) |
| pc_vector | input | 1 | Interrupt or trap vector reload |
| pc_target | input | 24 | Reload target address |
| boot_en | input | 1 | Boot segment check enable |
| boot_lo | input | 24 | Boot restricted window start, inclusive |
| boot_hi | input | 24 | Boot restricted window end, inclusive |
| secure_en | input | 1 | Secure segment check enable |
| secure_lo | input | 24 | Secure restricted window start, inclusive |
| secure_hi | input | 24 | Secure restricted window end, inclusive |
| rst_req | output | 1 | One-cycle reset request |
| rst_cause | output | 2 | Cause of the request (00 when idle) |

## Verification
Random traffic mixes fetch words with and without the illegal top byte, writes and pointer uses over all sixteen indices, and reloads of both kinds aimed near the window edges. This shows whether the initialized state builds up correctly over time and whether the decision depends on the reload kind. Directed cases probe lo-1, lo, hi and hi+1 with each segment enabled and disabled, which separates inclusive from exclusive comparisons and exposes an ignored enable. Further cases fire all three conditions at once to pin down the priority, write and use one register in the same cycle, and raise conditions in back-to-back cycles to test the one-cycle pulse.

// File: rtl/ird_pkg.sv
package ird_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_OPC    = 2'b01,
        CAUSE_UNINIT = 2'b10,
        CAUSE_SEC    = 2'b11
    } cause_e;

    typedef struct packed {
        logic   req;
        cause_e cause;
    } det_state_s;
endpackage

// File: rtl/ird_opc_chk.sv
module ird_opc_chk #(
    parameter int          IW      = 24,
    parameter int          OPW     = 8,
    parameter logic [7:0]  ILL_OPC = 8'h3F
) (
    input  logic          fetch_vld,
    input  logic [IW-1:0] fetch_word,
    output logic          opc_hit
);
    localparam int TOP = IW - 1;
    localparam int BOT = IW - OPW;

    always_comb begin
        opc_hit = fetch_vld && (fetch_word[TOP:BOT] == ILL_OPC[OPW-1:0]);
    end
endmodule

// File: rtl/ird_reg_track.sv
module ird_reg_track #(
    parameter int NREG   = 16,
    parameter int EXEMPT = NREG - 1,
    localparam int RIW   = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [RIW-1:0] wr_idx,
    input  logic           use_en,
    input  logic [RIW-1:0] use_idx,
    output logic           use_fault
);
    localparam logic [NREG-1:0] RST_VEC = {{(NREG-1){1'b0}}, 1'b1} << EXEMPT;

    logic [NREG-1:0] init_d, init_q;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == EXEMPT) begin : g_exempt
            assign init_d[i] = 1'b1;
        end else begin : g_track
            assign init_d[i] = init_q[i] | (wr_en && (wr_idx == RIW'(i)));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) init_q <= RST_VEC;
        else        init_q <= init_d;
    end

    always_comb begin
        use_fault = use_en && !init_q[use_idx];
    end

    AST_EXEMPT_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        init_q[EXEMPT]) else $error("exempt register lost init"); // R5

    AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(init_q)) & ~init_q) == '0)) else $error("init bit cleared"); // R4
endmodule

// File: rtl/ird_seg_chk.sv
module ird_seg_chk #(
    parameter int AW = 24
) (
    input  logic          chk,
    input  logic          en,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic [AW-1:0] tgt,
    output logic          hit
);
    always_comb begin
        hit = chk && en && (tgt >= lo) && (tgt <= hi);
    end
endmodule

// File: rtl/illegal_reset_det.sv
module illegal_reset_det
    import ird_pkg::*;
#(
    parameter int IW   = 24,
    parameter int AW   = 24,
    parameter int NREG = 16,
    localparam int RIW = $clog2(NREG),
    localparam int NSEG = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fetch_vld,
    input  logic [IW-1:0]  fetch_word,
    input  logic           wr_en,
    input  logic [RIW-1:0] wr_idx,
    input  logic           ptr_use,
    input  logic [RIW-1:0] ptr_idx,
    input  logic           pc_branch,
    input  logic           pc_vector,
    input  logic [AW-1:0]  pc_target,
    input  logic           boot_en,
    input  logic [AW-1:0]  boot_lo,
    input  logic [AW-1:0]  boot_hi,
    input  logic           secure_en,
    input  logic [AW-1:0]  secure_lo,
    input  logic [AW-1:0]  secure_hi,
    output logic           rst_req,
    output logic [1:0]     rst_cause
);
    logic            opc_hit, uninit_hit, sec_hit, pc_load;
    logic [NSEG-1:0] seg_en, seg_hit;
    logic [AW-1:0]   seg_lo [NSEG];
    logic [AW-1:0]   seg_hi [NSEG];
    det_state_s      st_d, st_q;

    assign pc_load   = pc_branch | pc_vector;
    assign seg_en    = {secure_en, boot_en};
    assign seg_lo[0] = boot_lo;
    assign seg_hi[0] = boot_hi;
    assign seg_lo[1] = secure_lo;
    assign seg_hi[1] = secure_hi;

    ird_opc_chk #(.IW(IW)) u_opc (
        .fetch_vld  (fetch_vld),
        .fetch_word (fetch_word),
        .opc_hit    (opc_hit)
    );

    ird_reg_track #(.NREG(NREG)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .use_en    (ptr_use),
        .use_idx   (ptr_idx),
        .use_fault (uninit_hit)
    );

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        ird_seg_chk #(.AW(AW)) u_seg (
            .chk (pc_load),
            .en  (seg_en[s]),
            .lo  (seg_lo[s]),
            .hi  (seg_hi[s]),
            .tgt (pc_target),
            .hit (seg_hit[s])
        );
    end

    assign sec_hit = |seg_hit;

    always_comb begin
        st_d = '{req: 1'b0, cause: CAUSE_NONE};
        if (!st_q.req) begin
            if (opc_hit)         st_d = '{req: 1'b1, cause: CAUSE_OPC};
            else if (sec_hit)    st_d = '{req: 1'b1, cause: CAUSE_SEC};
            else if (uninit_hit) st_d = '{req: 1'b1, cause: CAUSE_UNINIT};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{req: 1'b0, cause: CAUSE_NONE};
        else        st_q <= st_d;
    end

    assign rst_req   = st_q.req;
    assign rst_cause = st_q.cause;

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req) else $error("request longer than one cycle"); // R9

    AST_IDLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_req |-> (rst_cause == 2'b00)) else $error("cause without request"); // R9

    AST_OPC_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (opc_hit && !rst_req) |=> (rst_req && rst_cause == 2'b01)) else $error("opcode miss"); // R2

    AST_SEC_OVER_UNINIT: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_hit && !opc_hit && !rst_req) |=> (rst_cause == 2'b11)) else $error("security priority"); // R8

    AST_UNINIT_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (uninit_hit && !rst_req) |=> rst_req) else $error("uninit use miss"); // R3
endmodule

// File: tb/illegal_reset_det_tb.sv
module illegal_reset_det_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_vld = 0;
    logic [23:0] fetch_word = 0;
    logic        wr_en = 0;
    logic [3:0]  wr_idx = 0;
    logic        ptr_use = 0;
    logic [3:0]  ptr_idx = 0;
    logic        pc_branch = 0, pc_vector = 0;
    logic [23:0] pc_target = 0;
    logic        boot_en = 1;
    logic [23:0] boot_lo = 24'h000100, boot_hi = 24'h0001FF;
    logic        secure_en = 1;
    logic [23:0] secure_lo = 24'h004000, secure_hi = 24'h0047FF;
    logic        rst_req;
    logic [1:0]  rst_cause;

    int unsigned n_chk = 0, n_bad = 0;
    bit          done = 0;
    logic [15:0] m_init;
    bit          m_prev;

    always #4 clk = ~clk;

    illegal_reset_det u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_word(fetch_word),
        .wr_en(wr_en), .wr_idx(wr_idx), .ptr_use(ptr_use), .ptr_idx(ptr_idx),
        .pc_branch(pc_branch), .pc_vector(pc_vector), .pc_target(pc_target),
        .boot_en(boot_en), .boot_lo(boot_lo), .boot_hi(boot_hi),
        .secure_en(secure_en), .secure_lo(secure_lo), .secure_hi(secure_hi),
        .rst_req(rst_req), .rst_cause(rst_cause)
    );

    function automatic logic [2:0] model(input logic fv, input logic [23:0] fw,
                                         input logic pu, input logic [3:0] pi,
                                         input logic pl, input logic [23:0] pt);
        logic opc, sec, un;
        opc = fv && (fw[23:16] == 8'h3F);
        sec = pl && ((boot_en && pt >= boot_lo && pt <= boot_hi) ||
                     (secure_en && pt >= secure_lo && pt <= secure_hi));
        un  = pu && !m_init[pi];
        if (m_prev)   return 3'b000;
        if (opc)      return 3'b101;
        if (sec)      return 3'b111;
        if (un)       return 3'b110;
        return 3'b000;
    endfunction

    task automatic check(input string req, input logic [2:0] exp);
        n_chk++;
        if ({rst_req, rst_cause} !== exp) begin
            n_bad++;
            $display("FAIL %s: got req=%b cause=%b, expected req=%b cause=%b",
                     req, rst_req, rst_cause, exp[2], exp[1:0]);
        end
    endtask

    task automatic step(input string req, input logic fv, input logic [23:0] fw,
                        input logic we, input logic [3:0] wi,
                        input logic pu, input logic [3:0] pi,
                        input logic pb, input logic pv, input logic [23:0] pt);
        logic [2:0] exp;
        fetch_vld = fv; fetch_word = fw; wr_en = we; wr_idx = wi;
        ptr_use = pu; ptr_idx = pi; pc_branch = pb; pc_vector = pv; pc_target = pt;
        exp = model(fv, fw, pu, pi, pb | pv, pt);
        if (we) m_init[wi] = 1'b1;
        m_prev = exp[2];
        @(posedge clk);
        @(negedge clk);
        check(req, exp);
    endtask

    task automatic idle();
        step("idle", 0, 24'h0, 0, 4'd0, 0, 4'd0, 0, 0, 24'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_init = 16'h8000;
        m_prev = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", 3'b000);

        // R5: register 15 never faults; R1: register 3 starts uninitialized
        step("R5 w15 use", 0, 0, 0, 0, 1, 4'd15, 0, 0, 0);
        step("R1 w3 uninit", 0, 0, 0, 0, 1, 4'd3, 0, 0, 0);
        idle();
        // R4: same-cycle write and use still faults, later use clean
        step("R4 same cycle", 0, 0, 1, 4'd5, 1, 4'd5, 0, 0, 0);
        idle();
        step("R4 after write", 0, 0, 0, 0, 1, 4'd5, 0, 0, 0);
        // R2 illegal opcode; near value not illegal
        step("R2 opcode 3F", 1, 24'h3F1234, 0, 0, 0, 0, 0, 0, 0);
        idle();
        step("R2 opcode 3E", 1, 24'h3E1234, 0, 0, 0, 0, 0, 0, 0);
        step("R2 3F not valid", 0, 24'h3FFFFF, 0, 0, 0, 0, 0, 0, 0);
        // R7 inclusive bounds, R6 both kinds
        step("R7 boot lo-1", 0, 0, 0, 0, 0, 0, 1, 0, 24'h0000FF);
        step("R7 boot lo", 0, 0, 0, 0, 0, 0, 1, 0, 24'h000100);
        idle();
        step("R7 boot hi vec", 0, 0, 0, 0, 0, 0, 0, 1, 24'h0001FF);
        idle();
        step("R7 boot hi+1", 0, 0, 0, 0, 0, 0, 1, 0, 24'h000200);
        step("R6 secure vec", 0, 0, 0, 0, 0, 0, 0, 1, 24'h004400);
        idle();
        step("R7 secure hi+1", 0, 0, 0, 0, 0, 0, 0, 1, 24'h004800);
        boot_en = 0;
        step("R7 boot disabled", 0, 0, 0, 0, 0, 0, 1, 0, 24'h000150);
        boot_en = 1;
        // R8 priority
        step("R8 all three", 1, 24'h3F0000, 0, 0, 1, 4'd9, 1, 0, 24'h000180);
        idle();
        step("R8 sec over uninit", 0, 0, 0, 0, 1, 4'd9, 0, 1, 24'h004000);
        idle();
        // R9 back-to-back: second is dropped, third fires
        step("R9 first", 1, 24'h3F0000, 0, 0, 0, 0, 0, 0, 0);
        step("R9 dropped", 1, 24'h3F0000, 0, 0, 0, 0, 0, 0, 0);
        step("R9 next", 0, 0, 0, 0, 1, 4'd9, 0, 0, 0);

        // random phase, R2 R3 R4 R6 R8 R9
        for (int i = 0; i < 3000; i++) begin
            logic [23:0] fw, pt;
            logic [1:0]  pick;
            fw = $urandom;
            if ($urandom_range(0, 7) == 0) fw[23:16] = 8'h3F;
            pick = 2'($urandom_range(0, 3));
            case (pick)
                2'd0: pt = 24'h000100 + 24'($urandom_range(0, 2)) - 24'd1;
                2'd1: pt = 24'h0001FF + 24'($urandom_range(0, 1));
                2'd2: pt = 24'h004000 + 24'($urandom_range(0, 24'h900));
                default: pt = 24'($urandom);
            endcase
            step("R2/R3/R6/R8/R9 random",
                 1'($urandom_range(0, 3) == 0), fw,
                 1'($urandom_range(0, 5) == 0), 4'($urandom),
                 1'($urandom_range(0, 2) == 0), 4'($urandom),
                 1'($urandom_range(0, 4) == 0), 1'($urandom_range(0, 6) == 0), pt);
            if (i == 1500) begin
                rst_n = 1'b0;
                @(negedge clk);
                rst_n = 1'b1;
                m_init = 16'h8000;
                m_prev = 0;
                check("R1 re-reset", 3'b000);
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule